// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block gathers outgoing frames from a ring of buffer descriptors that software keeps in memory. Each descriptor is eight bytes long. It gives a buffer's location, its length and a few control flags. Software fills descriptors, marks them ready and pulses `start`. The engine then walks the ring from its current position. For each descriptor it fetches the buffer bytes in address order and pushes them out on a byte stream with a valid/ready handshake. It rewrites the descriptor with the ready flag cleared. It keeps going until it meets a descriptor that software has not yet handed over.

One frame may span several descriptors. The descriptor carrying the last flag closes the frame, and its final byte is tagged on the output stream. Frames are clamped at a fixed maximum size: bytes beyond the limit are skipped and a babble event is pulsed. Per-descriptor and per-frame completion events are pulsed so that an interrupt block can count them. All memory traffic goes through one word-wide request port that waits for an acknowledge.

Top module: `txr_ring_engine`

## Requirements
- R1: While and right after reset, `mem_req`, `out_valid`, `busy` and all three event outputs are low.
- R2: A `start` pulse begins a walk only when `enable` is high and the engine is idle. A `start` seen while a walk is running is dropped and does not cause a second walk.
- R3: A descriptor at word-aligned address D holds two 32-bit words. The word at D is {flags[15:0], length[15:0]} and the word at D+4 is the buffer byte address. Flag bit 15 is ready, bit 13 is wrap and bit 11 is last. Memory is 32-bit wide and big-endian: byte address A sits in bits [31-8*(A mod 4) -: 8] of the word at A with its two low bits cleared.
- R4: When a fetched descriptor has its ready bit clear, the walk ends without writing it. Its address becomes the starting point of the next walk.
- R5: Buffer bytes are streamed in address order, and a frame continues across descriptors. `out_last` is high only on the final byte of a frame, which is the last byte taken when a last-flagged descriptor is finished. A zero-length buffer contributes no byte.
- R6: Each consumed descriptor is written back at D as {flags with bit 15 cleared, original length}, and `evt_buf` pulses once for it.
- R7: A consumed descriptor with the last flag pulses `evt_frame` in the same cycle as `evt_buf`, and resets the running frame size to zero.
- R8: When the running frame size plus a buffer length exceeds 2032, only the bytes up to 2032 are taken and `evt_babble` pulses once for that descriptor.
- R9: After a descriptor with the wrap flag, the next descriptor is at the ring start address. Otherwise it is at D+8.
- R10: Writing the ring start (`ring_wr`) clears the two low bits of the written value and, when the engine is idle, also moves the current descriptor pointer to it.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold.
- R12: A memory request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack`.
- R13: A frame left open when a walk stops resumes on the next walk: the held bytes and the running size are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; gates `start` |
| start | input | 1 | One-cycle request to walk the ring |
| ring_wr | input | 1 | Write strobe for the ring start address |
| ring_wdata | input | ADDR_W | Ring start value (low two bits ignored) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data (descriptor write-back) |
| mem_ack | input | 1 | Request completed; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a frame |
| out_ready | input | 1 | Sink accepts the byte |
| evt_buf | output | 1 | Pulse: descriptor consumed |
| evt_frame | output | 1 | Pulse: frame completed |
| evt_babble | output | 1 | Pulse: descriptor clamped at maximum frame size |
| busy | output | 1 | A walk is in progress |

## Verification
The walker is driven with a single short frame and with a three-descriptor frame that mixes unaligned buffers, an empty buffer and a stalling sink. These show whether byte order, big-endian lane selection and last-marker placement survive handshake pauses. A two-descriptor ring whose second entry carries the wrap flag, started from an unaligned ring start value, separates wrapping from plain stepping and checks the address masking. A walk that stops in mid-frame and is later resumed shows that the held byte and the running size carry over between walks. A 2150-byte request over three descriptors, followed by a small frame, checks the clamp arithmetic, including a descriptor that contributes nothing once the limit is reached, and checks that the size count restarts. Start pulses given while disabled, and again in the middle of a walk, must each leave the engine idle.

// File: rtl/txr_pkg.sv
package txr_pkg;

    // Descriptor flag positions inside the first descriptor word's upper half
    localparam int unsigned FLG_READY = 15;
    localparam int unsigned FLG_WRAP  = 13;
    localparam int unsigned FLG_LAST  = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PTR,
        ST_PICK,
        ST_EMIT,
        ST_BYTE,
        ST_WB
    } txr_state_e;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] len;
    } txr_hdr_t;

    // Select a byte lane from a big-endian word
    function automatic logic [7:0] be_lane(input logic [31:0] w, input logic [1:0] sel);
        logic [7:0] b;
        case (sel)
            2'd0:    b = w[31:24];
            2'd1:    b = w[23:16];
            2'd2:    b = w[15:8];
            default: b = w[7:0];
        endcase
        return b;
    endfunction

    // Header word written back after consumption: ownership returned
    function automatic logic [31:0] wb_word(input txr_hdr_t h);
        logic [15:0] f;
        f = h.flags;
        f[FLG_READY] = 1'b0;
        return {f, h.len};
    endfunction

endpackage

// File: rtl/txr_clamp.sv
module txr_clamp #(
    parameter int unsigned MAX_FRAME = 2032,
    parameter int unsigned CNT_W     = $clog2(MAX_FRAME + 1)
) (
    input  logic [CNT_W-1:0] fcnt,
    input  logic [15:0]      len,
    output logic [15:0]      take,
    output logic             over
);
    logic [31:0] sum;
    logic [31:0] room;

    always_comb begin
        sum  = 32'(fcnt) + 32'(len);
        room = 32'(MAX_FRAME) - 32'(fcnt);
        over = (sum > 32'(MAX_FRAME));
        take = over ? room[15:0] : len;
    end
endmodule

// File: rtl/txr_holdback.sv
module txr_holdback (
    input  logic       clk,
    input  logic       rst,
    input  logic       cap,
    input  logic [7:0] cap_byte,
    input  logic       send,
    input  logic       send_last,
    input  logic       out_ready,
    output logic       has_byte,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       sent
);
    logic [7:0] pend_q;
    logic       has_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            has_q  <= 1'b0;
        end else if (cap) begin
            pend_q <= cap_byte;
            has_q  <= 1'b1;
        end else if (sent) begin
            has_q  <= 1'b0;
        end
    end

    always_comb begin
        has_byte  = has_q;
        out_valid = send && has_q;
        out_data  = pend_q;
        out_last  = send && send_last;
        sent      = out_valid && out_ready;
    end
endmodule

// File: rtl/txr_ring_engine.sv
module txr_ring_engine
    import txr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned MAX_FRAME = 2032
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              start,
    input  logic              ring_wr,
    input  logic [ADDR_W-1:0] ring_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              evt_buf,
    output logic              evt_frame,
    output logic              evt_babble,
    output logic              busy
);
    localparam int unsigned CNT_W = $clog2(MAX_FRAME + 1);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] DESC_STEP  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] PTR_OFS    = ADDR_W'(4);

    txr_state_e        state_q;
    txr_hdr_t          hdr_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] bptr_q;
    logic [15:0]       take_q;
    logic [CNT_W-1:0]  fcnt_q;

    logic [15:0] c_take;
    logic        c_over;
    logic        hb_cap;
    logic [7:0]  hb_byte;
    logic        hb_has;
    logic        hb_sent;
    logic [ADDR_W-1:0] next_desc;

    txr_clamp #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_clamp (
        .fcnt (fcnt_q),
        .len  (hdr_q.len),
        .take (c_take),
        .over (c_over)
    );

    assign hb_cap  = (state_q == ST_BYTE) && mem_ack;
    assign hb_byte = be_lane(mem_rdata, bptr_q[1:0]);

    txr_holdback u_hold (
        .clk       (clk),
        .rst       (rst),
        .cap       (hb_cap),
        .cap_byte  (hb_byte),
        .send      (state_q == ST_EMIT),
        .send_last (take_q == 16'd0),
        .out_ready (out_ready),
        .has_byte  (hb_has),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .sent      (hb_sent)
    );

    assign next_desc = hdr_q.flags[FLG_WRAP] ? base_q : (cur_q + DESC_STEP);

    // Memory request decode
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_HDR: begin
                mem_req  = 1'b1;
                mem_addr = cur_q;
            end
            ST_PTR: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + PTR_OFS;
            end
            ST_BYTE: begin
                mem_req  = 1'b1;
                mem_addr = bptr_q & ALIGN_MASK;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q;
                mem_wdata = wb_word(hdr_q);
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            hdr_q      <= '0;
            base_q     <= '0;
            cur_q      <= '0;
            bptr_q     <= '0;
            take_q     <= '0;
            fcnt_q     <= '0;
            evt_buf    <= 1'b0;
            evt_frame  <= 1'b0;
            evt_babble <= 1'b0;
        end else begin
            evt_buf    <= 1'b0;
            evt_frame  <= 1'b0;
            evt_babble <= 1'b0;

            if (ring_wr) begin
                base_q <= ring_wdata & ALIGN_MASK;
                if (state_q == ST_IDLE) cur_q <= ring_wdata & ALIGN_MASK;
            end

            case (state_q)
                ST_IDLE: begin
                    if (start && enable) state_q <= ST_HDR;
                end
                ST_HDR: begin
                    if (mem_ack) begin
                        hdr_q   <= txr_hdr_t'(mem_rdata);
                        state_q <= mem_rdata[16 + FLG_READY] ? ST_PTR : ST_IDLE;
                    end
                end
                ST_PTR: begin
                    if (mem_ack) begin
                        bptr_q     <= mem_rdata[ADDR_W-1:0];
                        take_q     <= c_take;
                        fcnt_q     <= fcnt_q + CNT_W'(c_take);
                        evt_babble <= c_over;
                        state_q    <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (take_q != 16'd0)
                        state_q <= hb_has ? ST_EMIT : ST_BYTE;
                    else if (hdr_q.flags[FLG_LAST] && hb_has)
                        state_q <= ST_EMIT;
                    else
                        state_q <= ST_WB;
                end
                ST_EMIT: begin
                    if (hb_sent) state_q <= ST_PICK;
                end
                ST_BYTE: begin
                    if (mem_ack) begin
                        bptr_q  <= bptr_q + ADDR_W'(1);
                        take_q  <= take_q - 16'd1;
                        state_q <= ST_PICK;
                    end
                end
                ST_WB: begin
                    if (mem_ack) begin
                        evt_buf <= 1'b1;
                        if (hdr_q.flags[FLG_LAST]) begin
                            evt_frame <= 1'b1;
                            fcnt_q    <= '0;
                        end
                        cur_q   <= next_desc;
                        state_q <= ST_HDR;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txr_ring_engine_chk.sv
module txr_ring_engine_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              start,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              out_valid,
    input logic [7:0]        out_data,
    input logic              out_last,
    input logic              out_ready,
    input logic              evt_buf,
    input logic              evt_frame,
    input logic              busy
);
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    a_r11_out_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    a_r6_wb_ready_clear: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !mem_wdata[31]);

    a_r7_frame_with_buf: assert property (@(posedge clk) disable iff (rst)
        evt_frame |-> evt_buf);

    a_r2_stay_idle: assert property (@(posedge clk) disable iff (rst)
        !busy && !(start && enable) |=> !busy);

    a_r3_word_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00);

    a_r5_stream_in_walk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);
endmodule

bind txr_ring_engine txr_ring_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/txr_ring_engine_tb.sv
module txr_ring_engine_tb;
    localparam int MAXF = 2032;
    localparam logic [15:0] F_R = 16'h8000;
    localparam logic [15:0] F_W = 16'h2000;
    localparam logic [15:0] F_L = 16'h0800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0, start = 1'b0, ring_wr = 1'b0;
    logic [31:0] ring_wdata = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        out_valid, out_last, out_ready;
    logic [7:0]  out_data;
    logic        evt_buf, evt_frame, evt_babble, busy;

    always #4 clk = ~clk;

    txr_ring_engine u_dut (
        .clk(clk), .rst(rst), .enable(enable), .start(start),
        .ring_wr(ring_wr), .ring_wdata(ring_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .evt_buf(evt_buf), .evt_frame(evt_frame), .evt_babble(evt_babble), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        if (i < 1024) return 32'h0;
        return {8'(i * 7 + 1), 8'(i * 13 + 5), 8'(i * 3 + 9), 8'(i)};
    endfunction

    // Memory model: one-cycle acknowledge, bench pokes through pk_*
    logic [31:0] mem [0:4095];
    logic        pk_en = 1'b0;
    logic [11:0] pk_a = '0;
    logic [31:0] pk_d = '0;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[13:2]];
                if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
            end
            if (pk_en) mem[pk_a] <= pk_d;
        end
    end

    // Sink stall generator
    logic [7:0] lfsr = 8'h5A;
    bit stall_en = 0;
    always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    assign out_ready = stall_en ? lfsr[0] : 1'b1;

    // Reference model state
    logic [31:0] rmem [0:4095];
    logic [8:0]  expq [$];
    int unsigned r_base = 0, r_cur = 0, r_fcnt = 0;
    bit          r_has = 0;
    logic [7:0]  r_pend = '0;
    int exp_buf = 0, exp_frm = 0, exp_bab = 0;
    int got_buf = 0, got_frm = 0, got_bab = 0;

    function automatic logic [7:0] rbyte(input int unsigned a);
        logic [31:0] w;
        w = rmem[(a >> 2) & 4095];
        return 8'(w >> (8 * (3 - (a & 3))));
    endfunction

    task automatic ref_walk();
        for (int it = 0; it < 64; it++) begin
            logic [31:0] h;
            int unsigned len, ptr, take;
            h = rmem[(r_cur >> 2) & 4095];
            if (!h[31]) break;
            len = h[15:0];
            ptr = rmem[((r_cur + 4) >> 2) & 4095];
            if (r_fcnt + len > MAXF) begin
                take = MAXF - r_fcnt;
                exp_bab++;
            end else take = len;
            for (int k = 0; k < int'(take); k++) begin
                if (r_has) expq.push_back({1'b0, r_pend});
                r_pend = rbyte(ptr + k);
                r_has = 1;
            end
            r_fcnt += take;
            if (h[27]) begin
                if (r_has) expq.push_back({1'b1, r_pend});
                r_has = 0;
                r_fcnt = 0;
                exp_frm++;
            end
            exp_buf++;
            rmem[(r_cur >> 2) & 4095] = h & 32'h7FFF_FFFF;
            r_cur = h[29] ? r_base : r_cur + 8;
        end
    endtask

    // Per-clock comparison monitors
    bit          pv_stall = 0, pv_req = 0;
    logic [8:0]  pv_out = '0;
    logic [32:0] pv_mem = '0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid && out_ready) begin
                if (expq.size() == 0) chk(0, "R5", "unexpected byte", {out_last, out_data}, 0);
                else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    chk({out_last, out_data} == e, "R5", "stream byte {last,data}", {out_last, out_data}, e);
                end
            end
            if (pv_stall)
                chk(out_valid && {out_last, out_data} == pv_out, "R11", "held output", {out_valid, out_last, out_data}, {1'b1, pv_out});
            if (pv_req)
                chk(mem_req && {mem_we, mem_addr} == pv_mem, "R12", "held request", {mem_req, mem_we, mem_addr}, {1'b1, pv_mem});
            if (evt_frame) chk(evt_buf, "R7", "frame pulse with buffer pulse", evt_buf, 1);
            pv_stall = out_valid && !out_ready;
            pv_out   = {out_last, out_data};
            pv_req   = mem_req && !mem_ack;
            pv_mem   = {mem_we, mem_addr};
            got_buf += int'(evt_buf);
            got_frm += int'(evt_frame);
            got_bab += int'(evt_babble);
        end
    end

    task automatic poke(input int unsigned a, input logic [31:0] d);
        rmem[(a >> 2) & 4095] = d;
        @(posedge clk); #2;
        pk_en = 1'b1; pk_a = 12'(a >> 2); pk_d = d;
        @(posedge clk); #2;
        pk_en = 1'b0;
    endtask

    task automatic put_desc(input int unsigned a, input logic [15:0] f,
                            input logic [15:0] len, input logic [31:0] p);
        poke(a, {f, len});
        poke(a + 4, p);
    endtask

    task automatic set_base(input logic [31:0] a);
        @(posedge clk); #2;
        ring_wr = 1'b1; ring_wdata = a;
        @(posedge clk); #2;
        ring_wr = 1'b0;
        r_base = a & ~32'd3;
        r_cur = r_base;
    endtask

    task automatic pulse_start();
        @(posedge clk); #2; start = 1'b1;
        @(posedge clk); #2; start = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        @(negedge clk);
        while (busy && n < 40000) begin @(negedge clk); n++; end
        chk(!busy, tag, "walk completes", busy, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic settle(input string tag);
        int bad = -1;
        chk(expq.size() == 0, tag, "bytes remaining", expq.size(), 0);
        chk(got_buf == exp_buf, "R6", "buffer events", got_buf, exp_buf);
        chk(got_frm == exp_frm, "R7", "frame events", got_frm, exp_frm);
        chk(got_bab == exp_bab, "R8", "babble events", got_bab, exp_bab);
        for (int i = 0; i < 4096; i++) if (bad < 0 && mem[i] !== rmem[i]) bad = i;
        if (bad < 0) chk(1, "R6", "memory image", 0, 0);
        else chk(0, "R6", $sformatf("memory word %0d", bad), mem[bad], rmem[bad]);
    endtask

    task automatic kick(input string tag);
        pulse_start();
        ref_walk();
        wait_idle(tag);
        settle(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) rmem[i] = pat(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet in reset
        chk({mem_req, out_valid, busy, evt_buf, evt_frame, evt_babble} == 6'b0, "R1", "reset outputs",
            {mem_req, out_valid, busy, evt_buf, evt_frame, evt_babble}, 0);
        @(posedge clk); #2; rst = 1'b0;
        @(negedge clk);
        chk({mem_req, out_valid, busy, evt_buf, evt_frame, evt_babble} == 6'b0, "R1", "after reset outputs",
            {mem_req, out_valid, busy, evt_buf, evt_frame, evt_babble}, 0);

        // R2: start ignored while disabled
        set_base(32'h100);
        put_desc(32'h100, F_R | F_L, 16'd5, 32'h1001);
        begin
            bit seen = 0;
            pulse_start();
            repeat (10) begin @(negedge clk); if (busy || mem_req) seen = 1; end
            chk(!seen, "R2", "start with enable low", seen, 0);
        end

        // R3 R5 R6 R7: single short frame, then stop at 0x108 (R4)
        enable = 1'b1;
        kick("R3");

        // R4: resumes at 0x108; multi-buffer frame with stalls and empty buffer (R5 R11)
        stall_en = 1;
        put_desc(32'h108, F_R, 16'd3, 32'h2002);
        put_desc(32'h110, F_R, 16'd0, 32'h0);
        put_desc(32'h118, F_R | F_L, 16'd4, 32'h2103);
        kick("R4");
        stall_en = 0;

        // R10 masking, R9 wrap
        set_base(32'h303);
        put_desc(32'h300, F_R | F_L, 16'd2, 32'h2200);
        put_desc(32'h308, F_R | F_W | F_L, 16'd3, 32'h2210);
        kick("R10");
        put_desc(32'h300, F_R | F_L, 16'd4, 32'h2300);
        kick("R9");

        // R13: frame open across walks
        set_base(32'h400);
        put_desc(32'h400, F_R, 16'd6, 32'h2400);
        kick("R13");
        put_desc(32'h408, F_R | F_L, 16'd2, 32'h2501);
        kick("R13");

        // R8: clamp at the maximum size, then a fresh frame
        set_base(32'h500);
        put_desc(32'h500, F_R, 16'd2000, 32'h1000);
        put_desc(32'h508, F_R, 16'd100, 32'h2000);
        put_desc(32'h510, F_R | F_L, 16'd50, 32'h2100);
        put_desc(32'h518, F_R | F_L, 16'd10, 32'h2200);
        kick("R8");

        // R2: start during a walk is dropped
        set_base(32'h600);
        put_desc(32'h600, F_R | F_L, 16'd40, 32'h2600);
        pulse_start();
        ref_walk();
        repeat (6) @(posedge clk);
        pulse_start();
        wait_idle("R2");
        begin
            bit seen = 0;
            repeat (20) begin @(negedge clk); if (busy) seen = 1; end
            chk(!seen, "R2", "no second walk", seen, 0);
        end
        settle("R2");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule